// File: doc/BRIEF.md
# Tagged Instruction Queue Breakpoint

This block is a program prefetch queue that lets a debug host set hardware breakpoints without any address comparison. Each 16-bit program word enters together with two active-low tag inputs, one for the upper byte and one for the lower byte. When tagging has been armed, an active tag becomes a mark bit that is stored with its byte. The mark moves through the queue with that byte. The upper byte of a word always leaves the queue before the lower byte.

When a marked byte reaches the head of the queue, the block withholds it from the execution side and raises a request to enter background debug mode. The request stays high until the debug side acknowledges that it has entered debug mode. That acknowledge disarms tagging and clears every stored mark, so the withheld byte issues normally once execution resumes. While tagging is armed, a busy output tells the serial debug logic to refuse commands. A flush, for example after a taken branch, empties the queue and its marks together.

The fetch side and the issue side both use valid/ready handshakes. A fetch is taken in a cycle where `fetch_valid` and `fetch_ready` are both high. `fetch_ready` depends only on free space and on `flush`, so it never waits on `fetch_valid`. An issue is taken in a cycle where `issue_valid` and `issue_ready` are both high. Once `issue_valid` is asserted it stays high until the byte is taken or a flush occurs. The tag sample is taken at the same clock edge as the word it marks. Tagging needs no operating-mode qualification.

Top module: `tagq_bkpt`

## Requirements
- R1: After reset, `fetch_ready` is 1 and `issue_valid`, `dbg_req` and `tag_busy` are all 0.
- R2: Bytes leave on `issue_byte` in fetch order, with the upper byte of each word (bits 15:8) before its lower byte (bits 7:0).
- R3: The queue holds three words (six bytes). `fetch_ready` is low whenever fewer than two byte slots are free. A fetch and an issue in the same cycle both complete.
- R4: A tag input is stored only while tagging is armed. A fetch with tags low while unarmed issues both bytes and leaves `dbg_req` at 0.
- R5: A one-cycle pulse on `tag_arm` sets `tag_busy` from the next cycle. `tag_busy` then stays high until a `dbg_ack`.
- R6: When the head byte is marked, `issue_valid` is 0, and `dbg_req` rises at the next clock edge.
- R7: `dbg_req` stays high until `dbg_ack`. `dbg_ack` clears `dbg_req`, `tag_busy` and every stored mark, so the held byte then issues.
- R8: Each byte carries its own mark. `tag_hi_n` low marks the upper byte and `tag_lo_n` low marks the lower byte. Unmarked bytes ahead of a marked byte still issue.
- R9: `flush` forces `fetch_ready` low in that cycle. It empties the queue and clears all marks, but does not change the armed state.
- R10: When `tag_arm` and `dbg_ack` are high in the same cycle, the acknowledge wins and tagging ends up disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; word and tags are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetched program word is offered |
| fetch_ready | output | 1 | The queue can take a word this cycle |
| fetch_word | input | 16 | Fetched program word; upper byte issues first |
| tag_hi_n | input | 1 | Active-low mark for the upper byte |
| tag_lo_n | input | 1 | Active-low mark for the lower byte |
| flush | input | 1 | Empty the queue and drop all marks |
| issue_valid | output | 1 | The head byte may be issued |
| issue_ready | input | 1 | The execution side takes the head byte |
| issue_byte | output | 8 | Head byte |
| tag_arm | input | 1 | Command pulse that arms tagging |
| tag_busy | output | 1 | Tagging is armed; serial debug commands must be refused |
| dbg_req | output | 1 | Request to enter background debug mode |
| dbg_ack | input | 1 | Debug mode has been entered |

## Verification
Two things can happen in the same cycle: a word is pushed while a byte is issued, and a flush meets an offered fetch. The bench provokes the first by streaming words with `issue_ready` held high, so the queue fills and drains at once. A byte-order scoreboard then judges that nothing was lost, duplicated or reordered. The bench provokes the second by holding `fetch_valid` high during the flush cycle. It checks that `fetch_ready` drops, that the word never appears, and that a marked word caught by the flush never raises a debug request.

// File: rtl/tagq_pkg.sv
package tagq_pkg;
  // one queued program byte with its breakpoint mark
  typedef struct packed {
    logic [7:0] data;
    logic       mark;
  } qbyte_t;
endpackage

// File: rtl/tagq_capture.sv
module tagq_capture
  import tagq_pkg::*;
(
  input  logic [15:0] word,
  input  logic [1:0]  tag_n,
  input  logic        armed,
  output qbyte_t      lane [2]
);
  // lane 1 is the upper byte, lane 0 the lower byte
  for (genvar l = 0; l < 2; l++) begin : g_lane
    assign lane[l].data = word[8*l +: 8];
    assign lane[l].mark = armed & ~tag_n[l];
  end
endmodule

// File: rtl/tagq_store.sv
module tagq_store
  import tagq_pkg::*;
#(
  parameter int WORDS = 3,
  localparam int SLOTS = 2 * WORDS,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  qbyte_t        push_hi,
  input  qbyte_t        push_lo,
  input  logic          pop,
  input  logic          flush,
  input  logic          clr_marks,
  output logic [CW-1:0] count,
  output qbyte_t        head,
  output logic          room2
);
  qbyte_t        mem [SLOTS];
  qbyte_t        nxt [SLOTS];
  logic [CW-1:0] ncnt;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) nxt[i] = mem[i];
    ncnt = count;
    if (pop) begin
      for (int i = 0; i < SLOTS - 1; i++) nxt[i] = mem[i + 1];
      nxt[SLOTS-1] = '0;
      ncnt = count - CW'(1);
    end
    if (push) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (CW'(i) == ncnt)          nxt[i] = push_hi;
        if (CW'(i) == ncnt + CW'(1)) nxt[i] = push_lo;
      end
      ncnt = ncnt + CW'(2);
    end
    if (clr_marks || flush)
      for (int i = 0; i < SLOTS; i++) nxt[i].mark = 1'b0;
    if (flush) ncnt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      count <= ncnt;
      for (int i = 0; i < SLOTS; i++) mem[i] <= nxt[i];
    end
  end

  assign head  = mem[0];
  assign room2 = (count <= CW'(SLOTS - 2));
endmodule

// File: rtl/tagq_arm.sv
module tagq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_cmd,
  input  logic dbg_ack,
  input  logic head_marked,
  output logic armed,
  output logic dbg_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      dbg_req <= 1'b0;
    end else begin
      if (dbg_ack)      armed <= 1'b0;
      else if (arm_cmd) armed <= 1'b1;
      if (dbg_ack)          dbg_req <= 1'b0;
      else if (head_marked) dbg_req <= 1'b1;
    end
  end
endmodule

// File: rtl/tagq_bkpt.sv
module tagq_bkpt
  import tagq_pkg::*;
#(
  parameter int WORDS = 3,
  localparam int SLOTS = 2 * WORDS,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_valid,
  output logic        fetch_ready,
  input  logic [15:0] fetch_word,
  input  logic        tag_hi_n,
  input  logic        tag_lo_n,
  input  logic        flush,
  output logic        issue_valid,
  input  logic        issue_ready,
  output logic [7:0]  issue_byte,
  input  logic        tag_arm,
  output logic        tag_busy,
  output logic        dbg_req,
  input  logic        dbg_ack
);
  qbyte_t        lane [2];
  qbyte_t        head;
  logic [CW-1:0] q_count;
  logic          room2, armed, push, pop, head_marked;

  tagq_capture u_cap (
    .word  (fetch_word),
    .tag_n ({tag_hi_n, tag_lo_n}),
    .armed (armed),
    .lane  (lane)
  );

  assign fetch_ready = room2 & ~flush;
  assign push        = fetch_valid & fetch_ready;
  assign head_marked = (q_count != '0) & head.mark;
  assign issue_valid = (q_count != '0) & ~head.mark;
  assign issue_byte  = head.data;
  assign pop         = issue_valid & issue_ready;
  assign tag_busy    = armed;

  tagq_store #(.WORDS(WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_hi   (lane[1]),
    .push_lo   (lane[0]),
    .pop       (pop),
    .flush     (flush),
    .clr_marks (dbg_ack),
    .count     (q_count),
    .head      (head),
    .room2     (room2)
  );

  tagq_arm u_arm (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_cmd     (tag_arm),
    .dbg_ack     (dbg_ack),
    .head_marked (head_marked),
    .armed       (armed),
    .dbg_req     (dbg_req)
  );
endmodule

// File: rtl/tagq_bkpt_chk.sv
module tagq_bkpt_chk #(
  parameter int SLOTS = 6,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_ready,
  input logic          flush,
  input logic          issue_valid,
  input logic          dbg_req,
  input logic          dbg_ack,
  input logic          tag_busy,
  input logic          head_marked,
  input logic [CW-1:0] q_count
);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(SLOTS));
  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count > CW'(SLOTS - 2)) |-> !fetch_ready);
  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_count == '0));
  // R6
  head_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_marked |-> !issue_valid);
  // R6
  req_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_marked && !dbg_ack) |=> dbg_req);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && !dbg_ack) |=> dbg_req);
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ack |=> (!dbg_req && !tag_busy && !head_marked));
  // R4
  mark_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_marked |-> tag_busy);
endmodule

bind tagq_bkpt tagq_bkpt_chk #(.SLOTS(2 * WORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_ready (fetch_ready),
  .flush       (flush),
  .issue_valid (issue_valid),
  .dbg_req     (dbg_req),
  .dbg_ack     (dbg_ack),
  .tag_busy    (tag_busy),
  .head_marked (head_marked),
  .q_count     (q_count)
);

// File: tb/test_tagq_bkpt.sv
`timescale 1ns/1ps
module test_tagq_bkpt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0, fetch_ready;
  logic [15:0] fetch_word = '0;
  logic        tag_hi_n = 1'b1, tag_lo_n = 1'b1;
  logic        flush = 1'b0;
  logic        issue_valid, issue_ready = 1'b0;
  logic [7:0]  issue_byte;
  logic        tag_arm = 1'b0, tag_busy, dbg_req, dbg_ack = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q [$];

  always #2.5 clk = ~clk;

  tagq_bkpt i_tagq_bkpt (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_word(fetch_word), .tag_hi_n(tag_hi_n), .tag_lo_n(tag_lo_n), .flush(flush),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_byte(issue_byte),
    .tag_arm(tag_arm), .tag_busy(tag_busy), .dbg_req(dbg_req), .dbg_ack(dbg_ack)
  );

  task automatic check_eq(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // monitor: pop expected bytes as the design issues them
  always @(negedge clk) begin
    if (rst_n && issue_valid && issue_ready) begin
      if (exp_q.size() == 0) check_eq("R2 unexpected issued byte", int'(issue_byte), -1);
      else check_eq("R2 issued byte order", int'(issue_byte), int'(exp_q.pop_front()));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: offer a word, record its bytes in the scoreboard once taken
  task automatic do_fetch(logic [15:0] w, logic hn, logic ln);
    fetch_valid = 1'b1; fetch_word = w; tag_hi_n = hn; tag_lo_n = ln;
    do @(negedge clk); while (!fetch_ready);
    exp_q.push_back(w[15:8]);
    exp_q.push_back(w[7:0]);
    @(posedge clk); #1;
    fetch_valid = 1'b0; tag_hi_n = 1'b1; tag_lo_n = 1'b1;
  endtask

  task automatic pulse_arm();
    tag_arm = 1'b1; step(1); tag_arm = 1'b0;
  endtask

  task automatic pulse_ack();
    dbg_ack = 1'b1; step(1); dbg_ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    step(3);
    @(negedge clk);
    check_eq("R1 fetch_ready in reset", fetch_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 issue_valid after reset", issue_valid, 0);
    check_eq("R1 dbg_req after reset", dbg_req, 0);
    check_eq("R1 tag_busy after reset", tag_busy, 0);
    @(posedge clk); #1;

    // R2 byte order
    issue_ready = 1'b1;
    do_fetch(16'hA15C, 1, 1);
    do_fetch(16'h3E07, 1, 1);
    step(6);
    check_eq("R2 all bytes issued", exp_q.size(), 0);

    // R3 full stall, then streaming with push and pop together
    issue_ready = 1'b0;
    do_fetch(16'h1001, 1, 1);
    do_fetch(16'h2002, 1, 1);
    do_fetch(16'h3003, 1, 1);
    @(negedge clk);
    check_eq("R3 fetch_ready low when full", fetch_ready, 0);
    check_eq("R3 issue_valid when full", issue_valid, 1);
    @(posedge clk); #1;
    issue_ready = 1'b1;
    for (int k = 0; k < 6; k++) do_fetch(16'h4040 + 16'(k * 257), 1, 1);
    step(14);
    check_eq("R3 streaming drained", exp_q.size(), 0);

    // R4 tags ignored while unarmed
    do_fetch(16'h5AA5, 0, 0);
    step(5);
    check_eq("R4 unarmed tag no request", dbg_req, 0);
    check_eq("R4 unarmed bytes issued", exp_q.size(), 0);

    // R5 arm
    pulse_arm();
    @(negedge clk);
    check_eq("R5 tag_busy after arm", tag_busy, 1);
    @(posedge clk); #1;

    // R6 / R7 upper-byte breakpoint
    do_fetch(16'h1122, 1, 1);
    do_fetch(16'h3344, 0, 1);
    step(6);
    check_eq("R6 bytes before mark issued", exp_q.size(), 2);
    check_eq("R6 marked head withheld", issue_valid, 0);
    check_eq("R6 dbg_req raised", dbg_req, 1);
    step(5);
    check_eq("R7 dbg_req held", dbg_req, 1);
    check_eq("R5 tag_busy held", tag_busy, 1);
    pulse_ack();
    @(negedge clk);
    check_eq("R7 dbg_req cleared by ack", dbg_req, 0);
    check_eq("R7 tag_busy cleared by ack", tag_busy, 0);
    @(posedge clk); #1;
    step(4);
    check_eq("R7 held byte issued", exp_q.size(), 0);

    // R8 lower-byte mark travels with its byte
    pulse_arm();
    issue_ready = 1'b0;
    do_fetch(16'h5566, 1, 0);
    do_fetch(16'h7788, 1, 1);
    issue_ready = 1'b1;
    step(6);
    check_eq("R8 upper byte issued, lower held", exp_q.size(), 3);
    check_eq("R8 dbg_req on lower mark", dbg_req, 1);
    pulse_ack();
    step(6);
    check_eq("R8 rest issued after ack", exp_q.size(), 0);

    // R9 flush with a fetch offered in the same cycle
    pulse_arm();
    issue_ready = 1'b0;
    do_fetch(16'h0102, 1, 1);
    do_fetch(16'h99AA, 0, 0);
    flush = 1'b1; fetch_valid = 1'b1; fetch_word = 16'hDEAD;
    @(negedge clk);
    check_eq("R9 fetch_ready low in flush", fetch_ready, 0);
    exp_q.delete();
    @(posedge clk); #1;
    flush = 1'b0; fetch_valid = 1'b0;
    @(negedge clk);
    check_eq("R9 empty after flush", issue_valid, 0);
    @(posedge clk); #1;
    do_fetch(16'hBBCC, 1, 1);
    issue_ready = 1'b1;
    step(5);
    check_eq("R9 new word issued", exp_q.size(), 0);
    check_eq("R9 flushed marks gone", dbg_req, 0);
    check_eq("R9 flush keeps armed", tag_busy, 1);

    // R10 ack beats arm
    tag_arm = 1'b1; dbg_ack = 1'b1;
    step(1);
    tag_arm = 1'b0; dbg_ack = 1'b0;
    @(negedge clk);
    check_eq("R10 ack wins over arm", tag_busy, 0);
    @(posedge clk); #1;

    summary();
    $finish;
  end
endmodule